// File: doc/BRIEF.md
# Receive Byte Queue with Trigger-Level Full Flag

This block buffers bytes coming out of a serial receiver in a sixteen-entry first-in first-out store. It tells software and a DMA engine when enough data has gathered. Software picks a trigger level through a two-bit select. Once the number of stored bytes reaches that level, a full flag goes high.

The flag is deliberately hard to drop. Software must first read the status while the flag is 1 and then write a 0 to it. That write only clears the flag if the queue has already been drained below the trigger level. When DMA is enabled, the flag drives a request line. Each DMA acknowledge pops one byte, and the flag falls by itself on the acknowledge that takes the count under the level.

A push into a full queue is discarded and raises a sticky overrun bit. That bit is released with the same read-then-write-zero handshake. The present fill count is available on an 8-bit output.

Top module: `rxq_trigger_fifo`

## Requirements
- R1: The queue holds up to 16 bytes and returns them in push order. `fillCount` shows the stored count in its low bits, and its upper bits read 0.
- R2: `fullFlag` is 1 in the same cycle that the count reaches the trigger level. `trigSel` selects the level: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14.
- R3: `fullFlag` never falls while the count is at or above the trigger level. It does not fall by itself when CPU reads take the count below the level.
- R4: The software clear needs two steps: a `statusRd` pulse while `fullFlag` is 1, then a `statusWrEn` pulse with `statusWrFull`=0. It clears the flag only if the count is below the level at that write. A status write that was not preceded by such a read leaves the flag unchanged.
- R5: `dmaReq` is 1 exactly while `fullFlag` and `dmaEn` are both 1. Each `dmaAck` pulse pops one byte, and the flag clears when that pop leaves the count below the level.
- R6: A `cpuDataRd` pulse on an empty queue leaves the count at 0 and pops nothing.
- R7: A push while 16 bytes are stored, with no pop in the same cycle, is dropped and sets the sticky `ovrFlag`.
- R8: `ovrFlag` clears only after a `statusRd` pulse while it is 1, followed by a `statusWrEn` pulse with `statusWrOvr`=0. A status write without that read leaves it set.
- R9: A push and a pop in the same cycle leave the count unchanged and keep first-in first-out order.
- R10: After reset the count is 0, and `fullFlag`, `ovrFlag` and `dmaReq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pushValid | input | 1 | Receiver delivers a byte this cycle |
| pushData | input | 8 | Received byte |
| cpuDataRd | input | 1 | CPU pops the head byte |
| cpuDataOut | output | 8 | Head byte, valid while the count is nonzero |
| statusRd | input | 1 | CPU reads the status; arms the clear of each flag that is 1 |
| statusWrEn | input | 1 | CPU writes the status |
| statusWrFull | input | 1 | Value written to the full flag |
| statusWrOvr | input | 1 | Value written to the overrun flag |
| trigSel | input | 2 | Trigger level select |
| dmaEn | input | 1 | Lets the full flag request DMA |
| dmaReq | output | 1 | DMA request |
| dmaAck | input | 1 | DMA pops one byte |
| fullFlag | output | 1 | Count has reached the trigger level |
| ovrFlag | output | 1 | Sticky overrun flag |
| fillCount | output | 8 | Stored byte count |

## Verification
The bench targets the corners of the flag handshake:
- **Zero write without an arming read.** A design that skipped the arming step would drop the flag.
- **Armed write while the queue is still at the level.** A design that cleared unconditionally would lose the flag with data still waiting.
- **DMA acknowledge that crosses the level.** A design that set the flag from the old count would hold the request one pop too long.

The bench also drives these queue corners:
- **Push into a full queue.** A dropped-byte bug shows up as a wrong byte in the drained order.
- **Read from an empty queue.** Mishandled pointers show up as a count that wraps.
- **Push and pop in the same cycle.** Mishandled pointers show up as reordered data.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic doPush;
    logic doPop;
  } rxqStrobe_t;
endpackage

// File: rtl/rxq_datapath.sv
module rxq_datapath
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  rxqStrobe_t       strobe,
  input  logic [WIDTH-1:0] pushData,
  output logic [WIDTH-1:0] headData,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (strobe.doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.doPush) wrPtr <= (wrPtr == PW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (strobe.doPop)  rdPtr <= (rdPtr == PW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({strobe.doPush, strobe.doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headData = mem[rdPtr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH)); // R1
  AST_NO_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.doPop && count == '0)); // R6
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doPush && strobe.doPop) |=> $stable(count)); // R9
endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL0 = 1,
  parameter int LVL1 = 4,
  parameter int LVL2 = 8,
  parameter int LVL3 = 14,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] count,
  input  logic          pushValid,
  input  logic          cpuDataRd,
  input  logic          dmaAck,
  input  logic          dmaEn,
  input  logic          statusRd,
  input  logic          statusWrEn,
  input  logic          statusWrFull,
  input  logic          statusWrOvr,
  input  logic [1:0]    trigSel,
  output rxqStrobe_t    strobe,
  output logic          fullFlag,
  output logic          ovrFlag,
  output logic          dmaReq
);
  logic [CW-1:0] trigLvl;
  logic [CW-1:0] afterCnt;
  logic fullArmed, ovrArmed;
  logic swClr, dmaClr, ovrClr, dropPush;

  always_comb begin
    case (trigSel)
      2'd0:    trigLvl = CW'(LVL0);
      2'd1:    trigLvl = CW'(LVL1);
      2'd2:    trigLvl = CW'(LVL2);
      default: trigLvl = CW'(LVL3);
    endcase
  end

  always_comb begin
    strobe.doPop  = (cpuDataRd || dmaAck) && (count != '0);
    strobe.doPush = pushValid && ((count != CW'(DEPTH)) || strobe.doPop);
  end

  assign afterCnt = count + CW'(strobe.doPush) - CW'(strobe.doPop);
  assign swClr    = statusWrEn && fullArmed && !statusWrFull;
  assign dmaClr   = dmaAck && strobe.doPop;
  assign ovrClr   = statusWrEn && ovrArmed && !statusWrOvr;
  assign dropPush = pushValid && !strobe.doPush;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fullFlag  <= 1'b0;
      ovrFlag   <= 1'b0;
      fullArmed <= 1'b0;
      ovrArmed  <= 1'b0;
    end else begin
      if (afterCnt >= trigLvl)    fullFlag <= 1'b1;
      else if (swClr || dmaClr)   fullFlag <= 1'b0;

      if (dropPush)               ovrFlag <= 1'b1;
      else if (ovrClr)            ovrFlag <= 1'b0;

      if (statusWrEn) begin
        fullArmed <= 1'b0;
        ovrArmed  <= 1'b0;
      end else if (statusRd) begin
        fullArmed <= fullFlag;
        ovrArmed  <= ovrFlag;
      end
    end
  end

  assign dmaReq = fullFlag && dmaEn;

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (count >= trigLvl && !strobe.doPop) |=> fullFlag); // R3
  AST_FLAG_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(fullFlag) |-> $past(dmaAck || (statusWrEn && fullArmed))); // R4
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ovrFlag && !statusWrEn) |=> ovrFlag); // R7
  AST_DROP_SETS_OVR: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && count == CW'(DEPTH) && !cpuDataRd && !dmaAck) |=> ovrFlag); // R7
endmodule

// File: rtl/rxq_trigger_fifo.sv
module rxq_trigger_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  parameter int CNT_OUT_W = 8,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pushValid,
  input  logic [WIDTH-1:0]     pushData,
  input  logic                 cpuDataRd,
  output logic [WIDTH-1:0]     cpuDataOut,
  input  logic                 statusRd,
  input  logic                 statusWrEn,
  input  logic                 statusWrFull,
  input  logic                 statusWrOvr,
  input  logic [1:0]           trigSel,
  input  logic                 dmaEn,
  output logic                 dmaReq,
  input  logic                 dmaAck,
  output logic                 fullFlag,
  output logic                 ovrFlag,
  output logic [CNT_OUT_W-1:0] fillCount
);
  rxqStrobe_t strobe;
  logic [CW-1:0] count;

  rxq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .count(count), .pushValid(pushValid),
    .cpuDataRd(cpuDataRd), .dmaAck(dmaAck), .dmaEn(dmaEn),
    .statusRd(statusRd), .statusWrEn(statusWrEn),
    .statusWrFull(statusWrFull), .statusWrOvr(statusWrOvr),
    .trigSel(trigSel), .strobe(strobe), .fullFlag(fullFlag),
    .ovrFlag(ovrFlag), .dmaReq(dmaReq)
  );

  rxq_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pushData(pushData),
    .headData(cpuDataOut), .count(count)
  );

  assign fillCount = CNT_OUT_W'(count);
endmodule

// File: tb/test_rxq_trigger_fifo.sv
`timescale 1ns/1ps
module test_rxq_trigger_fifo;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 0, cpuDataRd = 0, statusRd = 0, statusWrEn = 0;
  logic statusWrFull = 0, statusWrOvr = 0, dmaEn = 0, dmaAck = 0;
  logic [7:0] pushData = 0;
  logic [1:0] trigSel = 2'd3;
  logic [7:0] cpuDataOut, fillCount;
  logic dmaReq, fullFlag, ovrFlag;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rxq_trigger_fifo i_rxq_trigger_fifo (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushData(pushData),
    .cpuDataRd(cpuDataRd), .cpuDataOut(cpuDataOut), .statusRd(statusRd),
    .statusWrEn(statusWrEn), .statusWrFull(statusWrFull),
    .statusWrOvr(statusWrOvr), .trigSel(trigSel), .dmaEn(dmaEn),
    .dmaReq(dmaReq), .dmaAck(dmaAck), .fullFlag(fullFlag),
    .ovrFlag(ovrFlag), .fillCount(fillCount)
  );

  // vector: push, data, pop, checkData, expData, expCount
  localparam logic [23:0] VEC [0:8] = '{
    {1'b1, 8'hA1, 1'b0, 1'b0, 8'h00, 5'd1},
    {1'b1, 8'hB2, 1'b0, 1'b0, 8'h00, 5'd2},
    {1'b1, 8'hC3, 1'b1, 1'b1, 8'hA1, 5'd2},
    {1'b0, 8'h00, 1'b1, 1'b1, 8'hB2, 5'd1},
    {1'b0, 8'h00, 1'b1, 1'b1, 8'hC3, 5'd0},
    {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 5'd0},
    {1'b1, 8'h5A, 1'b0, 1'b0, 8'h00, 5'd1},
    {1'b1, 8'h6B, 1'b1, 1'b1, 8'h5A, 5'd1},
    {1'b0, 8'h00, 1'b1, 1'b1, 8'h6B, 5'd0}
  };

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearIns();
    pushValid = 0; cpuDataRd = 0; statusRd = 0; statusWrEn = 0;
    statusWrFull = 0; statusWrOvr = 0; dmaAck = 0; pushData = 0;
  endtask

  // drive at negedge, optionally capture head, settle after posedge
  task automatic cyc(input bit p, input logic [7:0] d, input bit rd, input bit ack,
                     input bit sRd, input bit sWr, input bit wF, input bit wO,
                     output logic [7:0] head);
    @(negedge clk);
    pushValid = p; pushData = d; cpuDataRd = rd; dmaAck = ack;
    statusRd = sRd; statusWrEn = sWr; statusWrFull = wF; statusWrOvr = wO;
    #1 head = cpuDataOut;
    @(posedge clk);
    #2 clearIns();
  endtask

  logic [7:0] h;

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    if (!done) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clearIns();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 count", fillCount, 0);
    check("R10 fullFlag", fullFlag, 0);
    check("R10 ovrFlag", ovrFlag, 0);
    check("R10 dmaReq", dmaReq, 0);

    // table: R1 order, R6 empty read, R9 push+pop
    for (int i = 0; i < 9; i++) begin
      logic [23:0] v;
      v = VEC[i];
      cyc(v[23], v[22:15], v[14], 0, 0, 0, 0, 0, h);
      if (v[13]) check($sformatf("R9 R1 head vec %0d", i), h, v[12:5]);
      check($sformatf("R6 R9 count vec %0d", i), fillCount, v[4:0]);
    end

    // R2 trigger at level 4
    trigSel = 2'd1;
    for (int i = 0; i < 3; i++) cyc(1, 8'h10 + 8'(i), 0, 0, 0, 0, 0, 0, h);
    check("R2 below level", fullFlag, 0);
    cyc(1, 8'h13, 0, 0, 0, 0, 0, 0, h);
    check("R2 at level", fullFlag, 1);
    cyc(0, 0, 1, 0, 0, 0, 0, 0, h);
    check("R3 no self clear", fullFlag, 1);
    cyc(0, 0, 0, 0, 0, 1, 0, 1, h);
    check("R4 unarmed write ignored", fullFlag, 1);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, h);
    cyc(0, 0, 0, 0, 0, 1, 0, 1, h);
    check("R4 armed clear", fullFlag, 0);
    cyc(1, 8'h14, 0, 0, 0, 0, 0, 0, h);
    check("R2 reset at level", fullFlag, 1);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, h);
    cyc(0, 0, 0, 0, 0, 1, 0, 1, h);
    check("R3 clear blocked at level", fullFlag, 1);

    // R5 DMA
    dmaEn = 1;
    #1 check("R5 dmaReq on", dmaReq, 1);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, h);
    check("R5 dma pop head", h, 8'h11);
    check("R5 dma pop count", fillCount, 3);
    check("R5 dma clears flag", fullFlag, 0);
    check("R5 dmaReq off", dmaReq, 0);
    dmaEn = 0;
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0, 0, 0, 0, h);
    check("R1 drained", fillCount, 0);

    // R7/R8 overrun at level 14
    trigSel = 2'd3;
    for (int i = 0; i < 16; i++) cyc(1, 8'(i * 3 + 1), 0, 0, 0, 0, 0, 0, h);
    check("R1 full count", fillCount, 16);
    check("R2 level 14", fullFlag, 1);
    cyc(1, 8'hEE, 0, 0, 0, 0, 0, 0, h);
    check("R7 drop count", fillCount, 16);
    check("R7 overrun set", ovrFlag, 1);
    cyc(0, 0, 0, 0, 0, 1, 1, 0, h);
    check("R8 unarmed write ignored", ovrFlag, 1);
    cyc(0, 0, 0, 0, 1, 0, 0, 0, h);
    cyc(0, 0, 0, 0, 0, 1, 1, 0, h);
    check("R8 armed clear", ovrFlag, 0);
    check("R8 full kept by write 1", fullFlag, 1);
    for (int i = 0; i < 16; i++) begin
      cyc(0, 0, 1, 0, 0, 0, 0, 0, h);
      check($sformatf("R1 R7 drain %0d", i), h, 8'(i * 3 + 1));
    end
    check("R1 empty", fillCount, 0);
    check("R3 flag after cpu drain", fullFlag, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule